// File: doc/BRIEF.md
# Fetch and Decode Timing Sequencer

This block is the timing heart of a single-accumulator processor with 16-bit words and 12-bit addresses. A 4-bit step counter drives a decoder that produces sixteen one-hot timing lines. The first three steps are fixed. In step 0 the program counter is copied into the address register. In step 1 the instruction word is read from the program store at that address and the program counter moves on by one. In step 2 the opcode field is decoded to eight one-hot lines, the low twelve bits go back into the address register, and the top bit is kept as the addressing-mode flag.

Downstream execute logic watches the timing and opcode lines and ends an instruction by pulsing a synchronous counter clear. The block also ends the sequence on its own when opcode line 3 is high during step 4. It gives the class of the fetched word: memory-reference for any opcode except all-ones. For the all-ones opcode, the top bit selects register-reference (0) or input/output (1). A halt input freezes the sequence in place. The program store is a synchronous-read array that is loaded through a simple write port before the sequence runs.

Top module: `fetch_seq_core`

## Requirements
- R1: Unless held or cleared, the step counter advances by one on every rising edge, `timing` is one-hot with bit n high in step n, and after step 15 comes step 0.
- R2: `sc_clr` high (without halt) returns the counter to step 0 at the next edge.
- R3: With opcode line 3 high during step 4, the counter returns to step 0 at the next edge, with no external clear.
- R4: At the edge that ends step 0, `ar_q` takes the value of `pc_q`.
- R5: At the edge that ends step 1, `ir_q` takes the stored word at `ar_q`, and `pc_q` increments by one modulo 4096 (0xFFF wraps to 0x000).
- R6: From step 2 on, `op_dec` is one-hot, with bit k high when `ir_q[14:12]` equals k.
- R7: At the edge that ends step 2, `ar_q` takes `ir_q[11:0]` and `mode_i` takes `ir_q[15]`.
- R8: `instr_class` is 2'b00 (memory-reference) when `ir_q[14:12]` is not 3'b111. For opcode 3'b111 it is 2'b01 (register-reference) when `ir_q[15]`=0 and 2'b10 (input/output) when `ir_q[15]`=1.
- R9: While `halt` is high, the step counter, `pc_q`, `ar_q`, `ir_q` and `mode_i` keep their values, even with `sc_clr` high. The sequence resumes where it stopped.
- R10: Synchronous reset puts the counter at step 0, clears `ir_q`, `ar_q` and `mode_i`, and loads `pc_q` from `start_addr`.
- R11: A word written through `mem_we`/`mem_waddr`/`mem_wdata` is stored at the store index given by the low `MEM_AW` bits of an address, and is what a later fetch from that address returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| start_addr | input | 12 | Program counter value loaded at reset |
| halt | input | 1 | Freezes counter and registers while high |
| sc_clr | input | 1 | Synchronous return to step 0 from execute logic |
| mem_we | input | 1 | Program store write enable |
| mem_waddr | input | 8 | Program store write index (MEM_AW bits) |
| mem_wdata | input | 16 | Program store write data |
| timing | output | 16 | One-hot step lines |
| op_dec | output | 8 | One-hot opcode lines |
| mode_i | output | 1 | Addressing-mode flag |
| instr_class | output | 2 | 00 memory-ref, 01 register-ref, 10 input/output |
| pc_q | output | 12 | Program counter |
| ar_q | output | 12 | Address register |
| ir_q | output | 16 | Instruction register |

## Verification
Each register result arrives exactly one edge after the step that causes it. `ar_q` holds the program counter in step 1. `ir_q` and the incremented `pc_q` appear in step 2, together with the combinational `op_dec` and `instr_class`. The reloaded `ar_q` and `mode_i` appear in step 3. An external or automatic clear shows as step 0 one edge later. The bench drives and samples only on falling edges, and it advances one falling edge per step. Every check is therefore made in the step where its value is first due. The halt test samples several frozen steps in a row, and then the first step after release.

// File: rtl/fsq_pkg.sv
package fsq_pkg;
  typedef enum logic [1:0] {
    CLS_MEM = 2'b00,
    CLS_REG = 2'b01,
    CLS_IO  = 2'b10
  } instr_cls_e;

  localparam int OPC_W = 3;
  localparam int OPC_N = 1 << OPC_W;
  localparam logic [OPC_W-1:0] OPC_NONMEM = '1;
endpackage

// File: rtl/fsq_step_counter.sv
module fsq_step_counter #(
  parameter int SC_W = 4,
  localparam int NT = 1 << SC_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  input  logic          clr,
  output logic [NT-1:0] t_line
);
  logic [SC_W-1:0] sc_q;

  always_ff @(posedge clk) begin
    if (rst)       sc_q <= '0;
    else if (hold) sc_q <= sc_q;
    else if (clr)  sc_q <= '0;
    else           sc_q <= sc_q + SC_W'(1);
  end

  for (genvar g = 0; g < NT; g++) begin : g_tdec
    assign t_line[g] = (sc_q == SC_W'(g));
  end
endmodule

// File: rtl/fsq_word_store.sv
module fsq_word_store #(
  parameter int WORD_W = 16,
  parameter int MEM_AW = 8,
  localparam int DEPTH = 1 << MEM_AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [MEM_AW-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              re,
  input  logic [MEM_AW-1:0] raddr,
  output logic [WORD_W-1:0] rq
);
  logic [WORD_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rq <= '0;
    else if (re) rq <= cells[raddr];
  end
endmodule

// File: rtl/fsq_op_decode.sv
module fsq_op_decode
  import fsq_pkg::*;
(
  input  logic [OPC_W:0]   hdr,
  output logic [OPC_N-1:0] op_dec,
  output instr_cls_e       cls
);
  logic [OPC_W-1:0] opc;
  logic             top_bit;

  assign opc     = hdr[OPC_W-1:0];
  assign top_bit = hdr[OPC_W];

  for (genvar g = 0; g < OPC_N; g++) begin : g_op
    assign op_dec[g] = (opc == OPC_W'(g));
  end

  always_comb begin
    if (opc != OPC_NONMEM) cls = CLS_MEM;
    else if (top_bit)      cls = CLS_IO;
    else                   cls = CLS_REG;
  end
endmodule

// File: rtl/fetch_seq_core.sv
module fetch_seq_core
  import fsq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int WORD_W = 16,
  parameter int SC_W   = 4,
  parameter int MEM_AW = 8,
  localparam int NT    = 1 << SC_W,
  localparam int OPC_HI = WORD_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              halt,
  input  logic              sc_clr,
  input  logic              mem_we,
  input  logic [MEM_AW-1:0] mem_waddr,
  input  logic [WORD_W-1:0] mem_wdata,
  output logic [NT-1:0]     timing,
  output logic [OPC_N-1:0]  op_dec,
  output logic              mode_i,
  output logic [1:0]        instr_class,
  output logic [ADDR_W-1:0] pc_q,
  output logic [ADDR_W-1:0] ar_q,
  output logic [WORD_W-1:0] ir_q
);
  logic       step_clr;
  logic       fetch_rd;
  instr_cls_e cls_w;

  assign step_clr = sc_clr | (op_dec[3] & timing[4]);
  assign fetch_rd = timing[1] & ~halt;

  fsq_step_counter #(.SC_W(SC_W)) u_steps (
    .clk    (clk),
    .rst    (rst),
    .hold   (halt),
    .clr    (step_clr),
    .t_line (timing)
  );

  fsq_word_store #(.WORD_W(WORD_W), .MEM_AW(MEM_AW)) u_store (
    .clk   (clk),
    .rst   (rst),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .re    (fetch_rd),
    .raddr (ar_q[MEM_AW-1:0]),
    .rq    (ir_q)
  );

  fsq_op_decode u_dec (
    .hdr    ({ir_q[WORD_W-1], ir_q[OPC_HI -: OPC_W]}),
    .op_dec (op_dec),
    .cls    (cls_w)
  );

  assign instr_class = cls_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= start_addr;
      ar_q   <= '0;
      mode_i <= 1'b0;
    end else if (!halt) begin
      if (timing[0]) ar_q <= pc_q;
      if (timing[1]) pc_q <= pc_q + ADDR_W'(1);
      if (timing[2]) begin
        ar_q   <= ir_q[ADDR_W-1:0];
        mode_i <= ir_q[WORD_W-1];
      end
    end
  end
endmodule

// File: rtl/fsq_checker.sv
module fsq_checker #(
  parameter int ADDR_W = 12,
  parameter int NT     = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              halt,
  input logic              sc_clr,
  input logic [NT-1:0]     timing,
  input logic              op_d3,
  input logic              op_d7,
  input logic              mode_i,
  input logic [1:0]        instr_class,
  input logic [ADDR_W-1:0] pc_q,
  input logic [ADDR_W-1:0] ar_q,
  input logic [ADDR_W-1:0] ir_addr,
  input logic              ir_mode
);
  a_r1_step_advance: assert property (@(posedge clk) disable iff (rst)
    (!halt && !sc_clr && !(op_d3 && timing[4]))
      |=> timing == {$past(timing[NT-2:0]), $past(timing[NT-1])});

  a_r2_ext_clear: assert property (@(posedge clk) disable iff (rst)
    (sc_clr && !halt) |=> timing[0]);

  a_r3_d3_t4_clear: assert property (@(posedge clk) disable iff (rst)
    (op_d3 && timing[4] && !halt) |=> timing[0]);

  a_r4_ar_from_pc: assert property (@(posedge clk) disable iff (rst)
    (timing[0] && !halt) |=> ar_q == $past(pc_q));

  a_r5_pc_step: assert property (@(posedge clk) disable iff (rst)
    (timing[1] && !halt) |=> pc_q == ADDR_W'($past(pc_q) + 1'b1));

  a_r7_ar_mode_load: assert property (@(posedge clk) disable iff (rst)
    (timing[2] && !halt) |=> (ar_q == $past(ir_addr)) && (mode_i == $past(ir_mode)));

  a_r8_mem_class: assert property (@(posedge clk) disable iff (rst)
    !op_d7 |-> instr_class == 2'b00);

  a_r8_nonmem_class: assert property (@(posedge clk) disable iff (rst)
    op_d7 |-> instr_class != 2'b00);

  a_r9_halt_freeze: assert property (@(posedge clk) disable iff (rst)
    halt |=> $stable(timing) && $stable(pc_q) && $stable(ar_q) && $stable(mode_i));
endmodule

bind fetch_seq_core fsq_checker #(.ADDR_W(ADDR_W), .NT(NT)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .halt        (halt),
  .sc_clr      (sc_clr),
  .timing      (timing),
  .op_d3       (op_dec[3]),
  .op_d7       (op_dec[7]),
  .mode_i      (mode_i),
  .instr_class (instr_class),
  .pc_q        (pc_q),
  .ar_q        (ar_q),
  .ir_addr     (ir_q[ADDR_W-1:0]),
  .ir_mode     (ir_q[WORD_W-1])
);

// File: tb/sim_fetch_seq_core.sv
module sim_fetch_seq_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] start_addr = 12'h010;
  logic        halt = 1'b0;
  logic        sc_clr = 1'b0;
  logic        mem_we = 1'b0;
  logic [7:0]  mem_waddr = '0;
  logic [15:0] mem_wdata = '0;
  logic [15:0] timing;
  logic [7:0]  op_dec;
  logic        mode_i;
  logic [1:0]  instr_class;
  logic [11:0] pc_q, ar_q;
  logic [15:0] ir_q;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  fetch_seq_core u0 (
    .clk(clk), .rst(rst), .start_addr(start_addr), .halt(halt), .sc_clr(sc_clr),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .timing(timing), .op_dec(op_dec), .mode_i(mode_i), .instr_class(instr_class),
    .pc_q(pc_q), .ar_q(ar_q), .ir_q(ir_q)
  );

  // {expected class, instruction word}
  localparam logic [17:0] VEC [10] = '{
    {2'b00, 16'h0123}, {2'b00, 16'h9456}, {2'b00, 16'h2789}, {2'b00, 16'hBABC},
    {2'b00, 16'h4DEF}, {2'b00, 16'hD001}, {2'b00, 16'h6FFF}, {2'b01, 16'h7800},
    {2'b10, 16'hF040}, {2'b00, 16'hE00A}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    mem_we = 1'b1; mem_waddr = a; mem_wdata = d;
    @(negedge clk);
    mem_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < 10; k++) wr(8'(8'h10 + k), VEC[k][15:0]);
    wr(8'h1A, 16'h0000);
    wr(8'h1B, 16'h3005);
    wr(8'h1C, 16'h1000);
    wr(8'hFF, 16'h7321);

    @(negedge clk);
    chk("R10 timing", 32'(timing), 32'h1);
    chk("R10 pc", 32'(pc_q), 32'h010);
    chk("R10 ir", 32'(ir_q), 32'h0);
    chk("R10 ar", 32'(ar_q), 32'h0);
    chk("R10 mode", 32'(mode_i), 32'h0);
    rst = 1'b0;

    for (int k = 0; k < 10; k++) begin
      logic [15:0] w;
      w = VEC[k][15:0];
      chk("R1 step0", 32'(timing), 32'h1);
      chk("R5 pc before fetch", 32'(pc_q), 32'(12'h010 + k));
      @(negedge clk);
      chk("R1 step1", 32'(timing), 32'h2);
      chk("R4 ar", 32'(ar_q), 32'(12'h010 + k));
      @(negedge clk);
      chk("R1 step2", 32'(timing), 32'h4);
      chk("R5 R11 ir", 32'(ir_q), 32'(w));
      chk("R5 pc inc", 32'(pc_q), 32'(12'h011 + k));
      chk("R6 op_dec", 32'(op_dec), 32'(8'h1 << w[14:12]));
      chk("R8 class", 32'(instr_class), 32'(VEC[k][17:16]));
      @(negedge clk);
      chk("R1 step3", 32'(timing), 32'h8);
      chk("R7 ar", 32'(ar_q), 32'(w[11:0]));
      chk("R7 mode", 32'(mode_i), 32'(w[15]));
      sc_clr = 1'b1;
      @(negedge clk);
      sc_clr = 1'b0;
      chk("R2 clear", 32'(timing), 32'h1);
    end

    for (int c = 1; c <= 16; c++) begin
      @(negedge clk);
      chk("R1 free run", 32'(timing), 32'(16'h1 << (c % 16)));
    end

    repeat (2) @(negedge clk);
    chk("R6 opcode 3", 32'(op_dec), 32'h08);
    repeat (2) @(negedge clk);
    chk("R3 step4", 32'(timing), 32'h10);
    @(negedge clk);
    chk("R3 auto clear", 32'(timing), 32'h1);

    @(negedge clk);
    chk("R9 pre-halt step1", 32'(timing), 32'h2);
    halt = 1'b1;
    for (int c = 0; c < 3; c++) begin
      sc_clr = (c == 1);
      @(negedge clk);
      chk("R9 timing held", 32'(timing), 32'h2);
      chk("R9 pc held", 32'(pc_q), 32'h01C);
      chk("R9 ir held", 32'(ir_q), 32'h3005);
      chk("R9 ar held", 32'(ar_q), 32'h01C);
    end
    halt = 1'b0; sc_clr = 1'b0;
    @(negedge clk);
    chk("R9 resume step2", 32'(timing), 32'h4);
    chk("R9 resume ir", 32'(ir_q), 32'h1000);
    chk("R9 resume pc", 32'(pc_q), 32'h01D);

    rst = 1'b1; start_addr = 12'hFFF;
    @(negedge clk);
    chk("R10 mid reset timing", 32'(timing), 32'h1);
    chk("R10 mid reset pc", 32'(pc_q), 32'hFFF);
    chk("R10 mid reset ir", 32'(ir_q), 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R4 ar top", 32'(ar_q), 32'hFFF);
    @(negedge clk);
    chk("R11 low-bit index", 32'(ir_q), 32'h7321);
    chk("R5 pc wrap", 32'(pc_q), 32'h000);
    chk("R8 register class", 32'(instr_class), 32'h1);
    chk("R6 opcode 7", 32'(op_dec), 32'h80);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule